// File: doc/BRIEF.md
# Topology-Aware PWM Edge Generator

This block drives a single PWM pin from a free-running switching-period counter and a digital duty command. For every switching segment it works out two edge times, t1 and t2. Where these land depends on the selected modulation scheme: trailing-edge, leading-edge or dual-edge. When the bridge flag is set, each period is cut into an even half and an odd half, and each half is treated as a segment of its own.

Two select fields choose which edge event sets the pin and which edge event clears it. The menu of events is: plain t1 or t2, t1 or t2 restricted to the even or the odd half, or t1 or t2 delayed by a programmable number of clocks. The pin edges therefore follow the power-stage topology rather than one fixed counter compare.

The block is meant to be instantiated once per switch leg. All of its legs share the same period, duty and mode inputs.

Top module: `pwm_edge_gen`

## Requirements
- R1: While reset is asserted, `pwm_o` is 0, `period_start_o` is 1 (the count is 0) and `half_odd_o` is 0. The latched edge times t1 and t2 are both 0.
- R2: The period length is P = max(`period_i`, 4) clocks, counted 0..P-1. `period_start_o` is high when the count is 0. With `bridge_i`=1 the segment length is H = floor(P/2), and `half_odd_o` is high for counts >= H. With `bridge_i`=0, H = P and `half_odd_o` stays 0. The position within the segment is the count, minus H when in the odd half.
- R3: t1 and t2 are computed from `duty_i`, `mode_i` and H, and latched on the clock edge at which the count enters a segment start (count 0, or count H in bridge mode). A change of `duty_i` inside a segment has no effect until the next segment.
- R4: Trailing-edge (`mode_i`=0, and also 3): with D = min(duty, H-1), t1 = 0 and t2 = D.
- R5: Leading-edge (`mode_i`=1): with D = min(duty, H-1), t2 = H-1 and t1 = H-1-D.
- R6: Dual-edge (`mode_i`=2): with D = min(duty, 2*floor((H-1)/2)), t1 = floor(H/2) - floor(D/2) and t2 = t1 + D. In every mode t1 <= t2 <= H-1.
- R7: Fall select codes: 0 = position equals t1; 1 = position equals t2; 2 and 3 = t1 and t2 in the even half only; 4 and 5 = t1 and t2 in the odd half only; 6 and 7 = delayed t1 and delayed t2.
- R8: The delayed event of an edge time t fires at position (t + E) mod H, where E = min(`delay_i`, H-1).
- R9: The rise select uses the same codes 0..7. Codes 8..15 never produce a set event.
- R10: On a clock edge where the fall event is active, `pwm_o` becomes 0. Otherwise, if the rise event is active, it becomes 1. Otherwise it holds. The pin changes one clock after the cycle in which the event position is present, and fall wins over rise when both occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Switching period in clocks (values below 4 act as 4) |
| duty_i | input | CNT_W | Duty command in clocks |
| mode_i | input | 2 | 0 trailing, 1 leading, 2 dual-edge, 3 trailing |
| bridge_i | input | 1 | Split each period into even and odd halves |
| rise_sel_i | input | 4 | Set event select |
| fall_sel_i | input | 3 | Clear event select |
| delay_i | input | DLY_W | Delay of the delayed edge events, in clocks |
| pwm_o | output | 1 | PWM output |
| period_start_o | output | 1 | High while the count is 0 |
| half_odd_o | output | 1 | High during the odd half in bridge mode |

## Verification
`period_start_o` and `half_odd_o` follow the count in the same cycle. `pwm_o` moves exactly one clock after the cycle in which its event position is present. A duty command takes effect from the first cycle of the segment that follows the edge at which it was latched.

The reference model steps on each rising edge using the same input values the design sees there. All three outputs are compared a quarter period later, so every prediction lines up with the register stage that produces it. Configuration is changed only at a period start, while duty is also swept inside segments to exercise the latch.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    typedef enum logic [1:0] {
        MOD_TRAIL = 2'd0,
        MOD_LEAD  = 2'd1,
        MOD_DUAL  = 2'd2,
        MOD_SPARE = 2'd3
    } mod_e;

    localparam int unsigned SEL_T1      = 0;
    localparam int unsigned SEL_T2      = 1;
    localparam int unsigned SEL_T1_EVEN = 2;
    localparam int unsigned SEL_T2_EVEN = 3;
    localparam int unsigned SEL_T1_ODD  = 4;
    localparam int unsigned SEL_T2_ODD  = 5;
    localparam int unsigned SEL_T1_DLY  = 6;
    localparam int unsigned SEL_T2_DLY  = 7;

    localparam int unsigned MIN_PERIOD  = 4;

endpackage

// File: rtl/pwm_edge_place.sv
module pwm_edge_place
    import pwm_edge_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic [CNT_W-1:0] seg_len_i,
    input  logic [CNT_W-1:0] duty_i,
    input  mod_e             mode_i,
    output logic [CNT_W-1:0] t1_o,
    output logic [CNT_W-1:0] t2_o
);

    logic [CNT_W-1:0] lim_full;
    logic [CNT_W-1:0] lim_dual;
    logic [CNT_W-1:0] centre;
    logic [CNT_W-1:0] dc;

    // Duty limits: full segment, and an even limit for the symmetric case
    assign lim_full = seg_len_i - CNT_W'(1);
    assign lim_dual = {lim_full[CNT_W-1:1], 1'b0};
    assign centre   = seg_len_i >> 1;

    always_comb begin
        dc   = '0;
        t1_o = '0;
        t2_o = '0;
        case (mode_i)
            MOD_LEAD: begin
                dc   = (duty_i > lim_full) ? lim_full : duty_i;
                t1_o = lim_full - dc;
                t2_o = lim_full;
            end
            MOD_DUAL: begin
                dc   = (duty_i > lim_dual) ? lim_dual : duty_i;
                t1_o = centre - (dc >> 1);
                t2_o = centre - (dc >> 1) + dc;
            end
            default: begin
                dc   = (duty_i > lim_full) ? lim_full : duty_i;
                t1_o = '0;
                t2_o = dc;
            end
        endcase
    end

endmodule

// File: rtl/pwm_event_sel.sv
module pwm_event_sel
    import pwm_edge_pkg::*;
#(
    parameter int unsigned CNT_W = 10,
    parameter int unsigned SEL_W = 3
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic             odd_i,
    input  logic [CNT_W-1:0] t1_i,
    input  logic [CNT_W-1:0] t2_i,
    input  logic [CNT_W-1:0] dly_i,
    input  logic [CNT_W-1:0] seg_len_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             ev_o
);

    localparam int unsigned SUM_W = CNT_W + 1;

    logic [1:0] hit;
    logic [1:0] dhit;

    // One lane per edge time: direct hit and delayed (wrapped) hit
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [CNT_W-1:0] base;
        logic [SUM_W-1:0] sum;
        logic [SUM_W-1:0] wrapped;

        assign base    = (g == 0) ? t1_i : t2_i;
        assign sum     = {1'b0, base} + {1'b0, dly_i};
        assign wrapped = (sum >= {1'b0, seg_len_i}) ? (sum - {1'b0, seg_len_i}) : sum;
        assign hit[g]  = (pos_i == base);
        assign dhit[g] = (pos_i == wrapped[CNT_W-1:0]);
    end

    always_comb begin
        ev_o = 1'b0;
        case (sel_i)
            SEL_W'(SEL_T1):      ev_o = hit[0];
            SEL_W'(SEL_T2):      ev_o = hit[1];
            SEL_W'(SEL_T1_EVEN): ev_o = hit[0] & ~odd_i;
            SEL_W'(SEL_T2_EVEN): ev_o = hit[1] & ~odd_i;
            SEL_W'(SEL_T1_ODD):  ev_o = hit[0] & odd_i;
            SEL_W'(SEL_T2_ODD):  ev_o = hit[1] & odd_i;
            SEL_W'(SEL_T1_DLY):  ev_o = dhit[0];
            SEL_W'(SEL_T2_DLY):  ev_o = dhit[1];
            default:             ev_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned DLY_W  = 6,
    parameter int unsigned RSEL_W = 4,
    parameter int unsigned FSEL_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic [1:0]        mode_i,
    input  logic              bridge_i,
    input  logic [RSEL_W-1:0] rise_sel_i,
    input  logic [FSEL_W-1:0] fall_sel_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic              pwm_o,
    output logic              period_start_o,
    output logic              half_odd_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] t1;
        logic [CNT_W-1:0] t2;
        logic             pwm;
    } state_t;

    state_t st_d, st_q;

    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] seg_len;
    logic [CNT_W-1:0] pos_cur;
    logic [CNT_W-1:0] t1_cur;
    logic [CNT_W-1:0] t2_cur;
    logic [CNT_W-1:0] dly_eff;
    logic [CNT_W-1:0] dly_ext;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] t1_new;
    logic [CNT_W-1:0] t2_new;
    logic             odd_cur;
    logic             seg_start_nxt;
    logic             rise_ev;
    logic             fall_ev;

    // Period, segment and position decode
    assign per_eff = (period_i < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : period_i;
    assign seg_len = bridge_i ? (per_eff >> 1) : per_eff;
    assign odd_cur = bridge_i && (st_q.cnt >= seg_len);
    assign pos_cur = odd_cur ? (st_q.cnt - seg_len) : st_q.cnt;
    assign cnt_nxt = (st_q.cnt >= per_eff - CNT_W'(1)) ? '0 : st_q.cnt + CNT_W'(1);
    assign seg_start_nxt = (cnt_nxt == '0) || (bridge_i && (cnt_nxt == seg_len));

    assign dly_ext = CNT_W'(delay_i);
    assign dly_eff = (dly_ext >= seg_len) ? (seg_len - CNT_W'(1)) : dly_ext;

    assign t1_cur  = st_q.t1;
    assign t2_cur  = st_q.t2;

    pwm_edge_place #(
        .CNT_W (CNT_W)
    ) u_place (
        .seg_len_i (seg_len),
        .duty_i    (duty_i),
        .mode_i    (mod_e'(mode_i)),
        .t1_o      (t1_new),
        .t2_o      (t2_new)
    );

    pwm_event_sel #(
        .CNT_W (CNT_W),
        .SEL_W (RSEL_W)
    ) u_rise_sel (
        .pos_i     (pos_cur),
        .odd_i     (odd_cur),
        .t1_i      (st_q.t1),
        .t2_i      (st_q.t2),
        .dly_i     (dly_eff),
        .seg_len_i (seg_len),
        .sel_i     (rise_sel_i),
        .ev_o      (rise_ev)
    );

    pwm_event_sel #(
        .CNT_W (CNT_W),
        .SEL_W (FSEL_W)
    ) u_fall_sel (
        .pos_i     (pos_cur),
        .odd_i     (odd_cur),
        .t1_i      (st_q.t1),
        .t2_i      (st_q.t2),
        .dly_i     (dly_eff),
        .seg_len_i (seg_len),
        .sel_i     (fall_sel_i),
        .ev_o      (fall_ev)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
        if (seg_start_nxt) begin
            st_d.t1 = t1_new;
            st_d.t2 = t2_new;
        end
        if (fall_ev) begin
            st_d.pwm = 1'b0;
        end else if (rise_ev) begin
            st_d.pwm = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o          = st_q.pwm;
    assign period_start_o = (st_q.cnt == '0);
    assign half_odd_o     = odd_cur;

endmodule

// File: rtl/pwm_edge_chk.sv
module pwm_edge_chk #(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned RSEL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm,
    input logic              odd,
    input logic              bridge,
    input logic [RSEL_W-1:0] rsel,
    input logic              rise_ev,
    input logic              fall_ev,
    input logic [CNT_W-1:0]  pos,
    input logic [CNT_W-1:0]  t1,
    input logic [CNT_W-1:0]  t2
);

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !pwm); // R1

    AST_ODD_NEEDS_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge |-> !odd); // R2

    AST_LATCH_AT_SEG_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(t1) || !$stable(t2)) |-> (pos == '0)); // R3

    AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        t1 <= t2); // R6

    AST_RSVD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rsel[RSEL_W-1] |-> !rise_ev); // R9

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_ev |=> !pwm); // R10

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_ev && !fall_ev) |=> pwm); // R10

    AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_ev && !fall_ev) |=> $stable(pwm)); // R10

endmodule

bind pwm_edge_gen pwm_edge_chk #(
    .CNT_W  (CNT_W),
    .RSEL_W (RSEL_W)
) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .pwm     (pwm_o),
    .odd     (half_odd_o),
    .bridge  (bridge_i),
    .rsel    (rise_sel_i),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .pos     (pos_cur),
    .t1      (t1_cur),
    .t2      (t2_cur)
);

// File: tb/pwm_edge_gen_tb_top.sv
module pwm_edge_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int DLY_W      = 6;
    localparam int WATCHDOG   = 200000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] period_i = 20;
    logic [CNT_W-1:0] duty_i = 0;
    logic [1:0]       mode_i = 0;
    logic             bridge_i = 0;
    logic [3:0]       rise_sel_i = 0;
    logic [2:0]       fall_sel_i = 1;
    logic [DLY_W-1:0] delay_i = 0;
    logic             pwm_o, period_start_o, half_odd_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    int m_cnt = 0, m_t1 = 0, m_t2 = 0;
    bit m_pwm = 0;

    pwm_edge_gen #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .period_i(period_i), .duty_i(duty_i),
        .mode_i(mode_i), .bridge_i(bridge_i), .rise_sel_i(rise_sel_i),
        .fall_sel_i(fall_sel_i), .delay_i(delay_i), .pwm_o(pwm_o),
        .period_start_o(period_start_o), .half_odd_o(half_odd_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int per_of(int p);
        return (p < 4) ? 4 : p;
    endfunction

    function automatic int seg_of(int p, bit br);
        return br ? per_of(p) / 2 : per_of(p);
    endfunction

    function automatic bit event_of(int code, int pos, bit odd, int t1, int t2, int dl, int h);
        case (code)
            0: return pos == t1;
            1: return pos == t2;
            2: return (pos == t1) && !odd;
            3: return (pos == t2) && !odd;
            4: return (pos == t1) && odd;
            5: return (pos == t2) && odd;
            6: return pos == (t1 + dl) % h;
            7: return pos == (t2 + dl) % h;
            default: return 0;
        endcase
    endfunction

    // Reference model, stepped with the values present at each rising edge
    always @(posedge clk) begin : model_step
        int p, h, pos, dl, d, lim, c;
        bit odd, rs, fl;
        if (!rst_n) begin
            m_cnt = 0; m_t1 = 0; m_t2 = 0; m_pwm = 0;
        end else begin
            p   = per_of(period_i);
            h   = seg_of(period_i, bridge_i);
            odd = bridge_i && (m_cnt >= h);
            pos = odd ? m_cnt - h : m_cnt;
            dl  = (delay_i >= h) ? h - 1 : delay_i;
            rs  = event_of(rise_sel_i, pos, odd, m_t1, m_t2, dl, h);
            fl  = event_of(fall_sel_i, pos, odd, m_t1, m_t2, dl, h);
            if (fl) m_pwm = 0;
            else if (rs) m_pwm = 1;
            m_cnt = (m_cnt >= p - 1) ? 0 : m_cnt + 1;
            if (m_cnt == 0 || (bridge_i && m_cnt == h)) begin
                d = duty_i;
                if (mode_i == 2) begin
                    lim = ((h - 1) / 2) * 2;
                    if (d > lim) d = lim;
                    c = h / 2;
                    m_t1 = c - d / 2;
                    m_t2 = m_t1 + d;
                end else if (mode_i == 1) begin
                    if (d > h - 1) d = h - 1;
                    m_t1 = h - 1 - d;
                    m_t2 = h - 1;
                end else begin
                    if (d > h - 1) d = h - 1;
                    m_t1 = 0;
                    m_t2 = d;
                end
            end
        end
    end

    // Compare a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            bit exp_odd;
            exp_odd = bridge_i && (m_cnt >= seg_of(period_i, bridge_i));
            n_checks++;
            if (pwm_o !== m_pwm) begin
                n_fail++;
                $display("FAIL %s pwm_o actual %0b expected %0b at %0t", tag, pwm_o, m_pwm, $time);
            end
            n_checks++;
            if (period_start_o !== (m_cnt == 0)) begin
                n_fail++;
                $display("FAIL R2 period_start_o actual %0b expected %0b", period_start_o, m_cnt == 0);
            end
            n_checks++;
            if (half_odd_o !== exp_odd) begin
                n_fail++;
                $display("FAIL R2 half_odd_o actual %0b expected %0b", half_odd_o, exp_odd);
            end
        end
    end

    task automatic at_period_start();
        @(negedge clk);
        while (!period_start_o) @(negedge clk);
    endtask

    task automatic cfg(string t, int per, int md, bit br, int dty, int rs, int fl, int dl);
        at_period_start();
        tag = t; period_i = per; mode_i = md; bridge_i = br; duty_i = dty;
        rise_sel_i = rs; fall_sel_i = fl; delay_i = dl;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state seen at the ports
        n_checks++;
        if (pwm_o !== 1'b0 || period_start_o !== 1'b1 || half_odd_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs actual %0b%0b%0b expected 010", pwm_o, period_start_o, half_odd_o);
        end
        rst_n = 1;
        run(30);
        cfg("R4", 20, 0, 0, 7, 0, 1, 0);    run(60);
        cfg("R4", 20, 3, 0, 30, 0, 1, 0);   run(45);
        cfg("R5", 20, 1, 0, 6, 0, 1, 0);    run(60);
        cfg("R6", 20, 2, 0, 9, 0, 1, 0);    run(60);
        cfg("R6", 21, 2, 0, 40, 0, 1, 0);   run(50);
        cfg("R3", 20, 0, 0, 3, 0, 1, 0);
        for (int i = 0; i < 12; i++) begin
            run(7);
            duty_i = (i * 5) % 19;
        end
        cfg("R7", 24, 0, 1, 5, 2, 3, 0);    run(72);
        cfg("R7", 24, 0, 1, 5, 4, 5, 0);    run(72);
        cfg("R7", 24, 0, 1, 3, 1, 4, 0);    run(72);
        cfg("R7", 24, 1, 1, 4, 0, 1, 0);    run(72);
        cfg("R7", 25, 2, 1, 6, 0, 1, 0);    run(75);
        cfg("R8", 20, 0, 0, 4, 0, 7, 5);    run(60);
        cfg("R8", 20, 0, 0, 4, 6, 7, 18);   run(60);
        cfg("R8", 24, 2, 1, 4, 6, 1, 63);   run(72);
        cfg("R9", 20, 0, 0, 8, 1, 1, 0);    run(40);
        for (int r = 8; r < 16; r++) begin
            cfg("R9", 20, 0, 0, 8, r, 0, 0);
            run(25);
        end
        cfg("R10", 20, 0, 0, 6, 1, 1, 0);   run(40);
        cfg("R10", 20, 0, 0, 6, 1, 0, 0);   run(40);
        cfg("R10", 20, 2, 0, 6, 0, 0, 0);   run(40);
        cfg("R2", 3, 0, 0, 1, 0, 1, 0);     run(20);
        cfg("R2", 13, 0, 1, 2, 0, 5, 0);    run(40);
        cfg("R2", 0, 0, 1, 1, 0, 1, 0);     run(20);
        finish_up();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual %0d cycles expected completion", WATCHDOG);
            finish_up();
        end
    end

endmodule